// File: doc/BRIEF.md
# FIFO Level Interrupt Comparator

This block sits beside the four FIFOs of an Ethernet MAC host interface: transmit data, transmit status, receive data and receive status. It holds one 32-bit threshold word with four 8-bit fields. Every clock it compares each FIFO's live occupancy against its own field and drives one level-interrupt line per FIFO. Software writes the threshold word through a simple write strobe and reads it back on a continuous read bus.

The two data FIFOs report free space in bytes. The block converts each of them to whole 64-byte blocks before it compares. The two status FIFOs report used space in DWORDs, and those counts are compared as they are. The transmit-side data flag and both status flags fire when the count rises above the threshold. The receive data flag fires when free space falls below it. All four flags are registered. Each one is a pure level that is recomputed every cycle, so no flag is sticky and none needs to be cleared.

Top module: `fifo_lvl_irq`

## Requirements
- R1: While reset is active and right after it, cfg_rdata reads 0x4800_0000 and all four interrupt outputs are 0.
- R2: When cfg_we is high at a clock edge, cfg_rdata equals cfg_wdata from that edge on. Without a write, cfg_rdata holds its value and returns the stored fields unchanged.
- R3: irq_tx_room is 1 when floor(tx_data_free_bytes / 64) > cfg[31:24].
- R4: irq_tx_stat is 1 when tx_stat_used_dw > cfg[23:16].
- R5: irq_rx_room is 1 when floor(rx_data_free_bytes / 64) < cfg[15:8]. With that field at 0, the flag is never 1.
- R6: irq_rx_stat is 1 when rx_stat_used_dw > cfg[7:0].
- R7: Each interrupt output is registered. After an edge it shows the comparison of the counts and thresholds present at that edge. A count change therefore appears one edge later, and a threshold write appears two edges later.
- R8: A byte count that is not a multiple of 64 is truncated. For example, 127 bytes counts as 1 block and 128 bytes counts as 2 blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the threshold word |
| cfg_wdata | input | 32 | Threshold word to write |
| cfg_rdata | output | 32 | Stored threshold word |
| tx_data_free_bytes | input | BYTE_W | Transmit data FIFO free space, bytes |
| tx_stat_used_dw | input | DW_W | Transmit status FIFO used space, DWORDs |
| rx_data_free_bytes | input | BYTE_W | Receive data FIFO free space, bytes |
| rx_stat_used_dw | input | DW_W | Receive status FIFO used space, DWORDs |
| irq_tx_room | output | 1 | Transmit data free space above threshold |
| irq_tx_stat | output | 1 | Transmit status used space above threshold |
| irq_rx_room | output | 1 | Receive data free space below threshold |
| irq_rx_stat | output | 1 | Receive status used space above threshold |

## Verification
The hardest cases to reach from the ports are the exact boundaries: a byte count one below a 64-byte multiple, and a block count equal to its threshold, where strict comparison must hold the flag low. Random counts almost never land on these values. The stimulus therefore writes small thresholds and then steps the counts by hand across each edge (127/128 bytes, equality, and a zero receive threshold). It also changes a threshold and a count in the same cycle, to expose any mix-up between the two latencies.

// File: rtl/fifo_lvl_pkg.sv
package fifo_lvl_pkg;
  localparam int FIELD_W   = 8;
  localparam int N_FLAGS   = 4;
  localparam int BLK_SHIFT = 6;
  localparam logic [31:0] CFG_RESET = 32'h4800_0000;

  typedef enum logic { SENSE_ABOVE, SENSE_BELOW } sense_e;

  // flag order: 0 rx_stat, 1 rx_room, 2 tx_stat, 3 tx_room (matches field order)
  function automatic sense_e sense_of(input int idx);
    return (idx == 1) ? SENSE_BELOW : SENSE_ABOVE;
  endfunction

  function automatic logic [31:0] bytes_to_blocks(input logic [31:0] nbytes);
    return nbytes >> BLK_SHIFT;
  endfunction

  function automatic logic level_hit(input sense_e s, input logic [31:0] cnt,
                                     input logic [FIELD_W-1:0] thr);
    logic [31:0] t;
    t = {{(32-FIELD_W){1'b0}}, thr};
    return (s == SENSE_ABOVE) ? (cnt > t) : (cnt < t);
  endfunction
endpackage

// File: rtl/fifo_lvl_cfg_reg.sv
module fifo_lvl_cfg_reg #(
  parameter int          WORD_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL[WORD_W-1:0];
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/fifo_lvl_cmp.sv
module fifo_lvl_cmp
  import fifo_lvl_pkg::*;
#(
  parameter sense_e SENSE = SENSE_ABOVE
) (
  input  logic [31:0]        cnt,
  input  logic [FIELD_W-1:0] thr,
  output logic               hit
);
  always_comb hit = level_hit(SENSE, cnt, thr);
endmodule

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq
  import fifo_lvl_pkg::*;
#(
  parameter int BYTE_W = 16,
  parameter int DW_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [BYTE_W-1:0] tx_data_free_bytes,
  input  logic [DW_W-1:0]   tx_stat_used_dw,
  input  logic [BYTE_W-1:0] rx_data_free_bytes,
  input  logic [DW_W-1:0]   rx_stat_used_dw,
  output logic              irq_tx_room,
  output logic              irq_tx_stat,
  output logic              irq_rx_room,
  output logic              irq_rx_stat
);
  localparam int WORD_W = FIELD_W * N_FLAGS;

  logic [WORD_W-1:0]  cfg_q;
  logic [31:0]        norm_cnt [N_FLAGS];
  logic [N_FLAGS-1:0] hit_now;
  logic [N_FLAGS-1:0] irq_q;

  // named views for the checker
  logic [31:0] tx_blocks, rx_blocks;

  fifo_lvl_cfg_reg #(.WORD_W(WORD_W), .RESET_VAL(CFG_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  always_comb begin
    tx_blocks   = bytes_to_blocks(32'(tx_data_free_bytes));
    rx_blocks   = bytes_to_blocks(32'(rx_data_free_bytes));
    norm_cnt[0] = 32'(rx_stat_used_dw);
    norm_cnt[1] = rx_blocks;
    norm_cnt[2] = 32'(tx_stat_used_dw);
    norm_cnt[3] = tx_blocks;
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_cmp
    fifo_lvl_cmp #(.SENSE(sense_of(i))) u_cmp (
      .cnt(norm_cnt[i]),
      .thr(cfg_q[i*FIELD_W +: FIELD_W]),
      .hit(hit_now[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= hit_now;
  end

  assign cfg_rdata   = cfg_q;
  assign irq_rx_stat = irq_q[0];
  assign irq_rx_room = irq_q[1];
  assign irq_tx_stat = irq_q[2];
  assign irq_tx_room = irq_q[3];
endmodule

// File: rtl/fifo_lvl_irq_chk.sv
module fifo_lvl_irq_chk #(
  parameter int BYTE_W = 16,
  parameter int DW_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [31:0]       cfg_wdata,
  input logic [31:0]       cfg_rdata,
  input logic [BYTE_W-1:0] tx_data_free_bytes,
  input logic [DW_W-1:0]   tx_stat_used_dw,
  input logic [BYTE_W-1:0] rx_data_free_bytes,
  input logic [DW_W-1:0]   rx_stat_used_dw,
  input logic              irq_tx_room,
  input logic              irq_tx_stat,
  input logic              irq_rx_room,
  input logic              irq_rx_stat
);
  p_irq_clear_in_reset_r7: assert property (@(posedge clk)
    !rst_n |=> (!rst_n && {irq_tx_room, irq_tx_stat, irq_rx_room, irq_rx_stat} == 4'b0) || rst_n);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  p_tx_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_tx_room == ((32'($past(tx_data_free_bytes)) / 64) > 32'($past(cfg_rdata[31:24]))));

  p_tx_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_tx_stat == (32'($past(tx_stat_used_dw)) > 32'($past(cfg_rdata[23:16]))));

  p_rx_room_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[15:8] == 8'd0) |=> !irq_rx_room);

  p_rx_stat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> irq_rx_stat == (32'($past(rx_stat_used_dw)) > 32'($past(cfg_rdata[7:0]))));
endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk #(.BYTE_W(BYTE_W), .DW_W(DW_W)) u_chk (.*);

// File: tb/fifo_lvl_irq_tb.sv
`timescale 1ns/1ps
module fifo_lvl_irq_tb;
  localparam int BYTE_W = 16;
  localparam int DW_W   = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [BYTE_W-1:0] txb = '0, rxb = '0;
  logic [DW_W-1:0] txs = '0, rxs = '0;
  logic irq_tx_room, irq_tx_stat, irq_rx_room, irq_rx_stat;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_lvl_irq #(.BYTE_W(BYTE_W), .DW_W(DW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_data_free_bytes(txb), .tx_stat_used_dw(txs),
    .rx_data_free_bytes(rxb), .rx_stat_used_dw(rxs),
    .irq_tx_room(irq_tx_room), .irq_tx_stat(irq_tx_stat),
    .irq_rx_room(irq_rx_room), .irq_rx_stat(irq_rx_stat)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: integers, whole-number block division
  int m_reg = 32'h4800_0000;
  bit m_tr, m_ts, m_rr, m_rs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 32'h4800_0000; m_tr = 0; m_ts = 0; m_rr = 0; m_rs = 0;
    end else begin
      m_tr = (int'(txb) / 64) > ((m_reg >> 24) & 255);
      m_ts = int'(txs) > ((m_reg >> 16) & 255);
      m_rr = (int'(rxb) / 64) < ((m_reg >> 8) & 255);
      m_rs = int'(rxs) > (m_reg & 255);
      if (cfg_we) m_reg = cfg_wdata;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 readback", cfg_rdata, m_reg);
    chk("R3 tx_room",  irq_tx_room, m_tr);
    chk("R4 tx_stat",  irq_tx_stat, m_ts);
    chk("R5 rx_room",  irq_rx_room, m_rr);
    chk("R6 rx_stat",  irq_rx_stat, m_rs);
  end

  task automatic wr(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic counts(input int tb, input int ts, input int rb, input int rs);
    @(negedge clk); txb = tb[BYTE_W-1:0]; txs = ts[DW_W-1:0];
    rxb = rb[BYTE_W-1:0]; rxs = rs[DW_W-1:0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset rdata", cfg_rdata, 32'h4800_0000);
    chk("R1 reset irqs", {irq_tx_room, irq_tx_stat, irq_rx_room, irq_rx_stat}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset irqs", {irq_tx_room, irq_tx_stat, irq_rx_room, irq_rx_stat}, 0);

    // R8 truncation: threshold 1 block
    wr(32'h0100_0000);
    counts(127, 0, 0, 0); @(negedge clk);
    chk("R8 127 bytes is 1 block", irq_tx_room, 0);
    counts(128, 0, 0, 0); @(negedge clk);
    chk("R8 128 bytes is 2 blocks", irq_tx_room, 1);

    // R5 zero threshold never fires, then boundary at 4 blocks
    counts(0, 0, 0, 0); @(negedge clk);
    chk("R5 zero threshold", irq_rx_room, 0);
    wr(32'h0000_0400);
    counts(0, 0, 255, 0); @(negedge clk);
    chk("R5 3 blocks < 4", irq_rx_room, 1);
    counts(0, 0, 256, 0); @(negedge clk);
    chk("R5 4 blocks not < 4", irq_rx_room, 0);

    // R4 / R6 equality boundary
    wr(32'h0010_0020);
    counts(0, 16, 0, 32); @(negedge clk);
    chk("R4 equal not above", irq_tx_stat, 0);
    chk("R6 equal not above", irq_rx_stat, 0);
    counts(0, 17, 0, 33); @(negedge clk);
    chk("R4 above", irq_tx_stat, 1);
    chk("R6 above", irq_rx_stat, 1);

    // R7 latency: count change visible only after one edge
    @(negedge clk); txs = 10'd0;
    chk("R7 before edge", irq_tx_stat, 1);
    @(negedge clk);
    chk("R7 after edge", irq_tx_stat, 0);

    // random traffic; model compares every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      txb = BYTE_W'($urandom_range(0, 20000));
      rxb = BYTE_W'($urandom_range(0, 20000));
      txs = DW_W'($urandom);
      rxs = DW_W'($urandom);
      cfg_we = ($urandom_range(0, 7) == 0);
      cfg_wdata = $urandom;
    end
    @(negedge clk); cfg_we = 1'b0;

    // mid-run reset: R1 / R7
    wr(32'h0000_0000);
    counts(5000, 500, 0, 500);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 irqs clear in reset", {irq_tx_room, irq_tx_stat, irq_rx_room, irq_rx_stat}, 0);
    chk("R1 rdata in reset", cfg_rdata, 32'h4800_0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule